// File: doc/BRIEF.md
# Reward-Decomposition Explanation Engine

This block explains why one candidate action is, or is not, preferred over another when each action's value is split into several reward components. It accepts one vector of signed fixed-point Q-values per action, with one entry per reward component. It then forms the per-component advantage of the first action over the second and decides the preference. Finally it reduces the explanation to two small sets of components, each given as a bitmask where bit i stands for component i.

The positive set is the fewest advantaged components whose combined advantage strictly outweighs the combined disadvantage. A necessity value is then formed: the positive set's sum minus its weakest member. The negative set is the fewest disadvantaged components whose combined magnitude strictly exceeds that value. When such a negative set exists, every member of the positive set is marked as needed.

A single start pulse launches a run. The engine walks the components one per cycle to form the sums. It then selects set members one per cycle, and raises a one-cycle done strobe when all results are stable.

Top module: `rdx_explain_engine`

## Requirements
- R1: The advantage of component i is q_a[i] - q_b[i], evaluated one bit wider than the inputs, so no input pair can overflow. With 16-bit inputs, 32767 - (-32768) gives +65535 and the opposite pair gives -65535.
- R2: `prefer` is 1 only when the sum of the first action's Q-values is strictly greater than the sum of the second's. Equal sums give 0.
- R3: The disadvantage d is the sum of the magnitudes of all negative advantages. `pos_mask` is built from the positive advantages, largest first, stopping as soon as the running sum is strictly greater than d. If the positive advantages run out first, `pos_mask` holds all of them.
- R4: Among components of equal magnitude, the lower index is taken first, for both sets.
- R5: The necessity value v is the positive set's sum minus its smallest member. `neg_mask` is built from the negative advantages, largest magnitude first, stopping once the running magnitude is strictly greater than v. If they run out first, `neg_mask` is all zeros.
- R6: `necessary` is 1 exactly when a negative set was found, that is, when `neg_mask` is non-zero at done.
- R7: With no positive advantage, `pos_mask`, `neg_mask`, `prefer` and `necessary` are all 0 at done.
- R8: The inputs are captured on the clock edge that samples `start`. Later input changes, and `start` pulses while `busy` is high, have no effect on the run in progress.
- R9: `done` is high for exactly one cycle. The results stay unchanged after it until the next accepted start. After reset, `done`, `busy` and all results are 0.
- R10: For an input with exactly one positive advantage and no negative one, `done` is high after the NCOMP+2-th clock edge following the start edge (9 edges for 7 components).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse; captures q_a and q_b |
| q_a | input | NCOMP*QW | Signed Q-values of action one, component i at bits i*QW |
| q_b | input | NCOMP*QW | Signed Q-values of action two, same layout |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle strobe: results valid |
| prefer | output | 1 | Action one preferred |
| pos_mask | output | NCOMP | Minimal sufficient advantaged components |
| neg_mask | output | NCOMP | Minimal disadvantaged components beating v |
| necessary | output | 1 | Every member of pos_mask is needed |

## Verification
The run length depends on the data. After the start edge there are NCOMP summing cycles. One cycle follows per selected positive member, plus one more if the positives run out. Then one cycle follows per selected negative member, plus one more if they run out, and `done` shows after the last of these edges. The bench therefore samples on falling edges and counts edges from the start edge until `done`. It compares that count exactly for the single-positive case (NCOMP+2) and bounds it elsewhere. It reads the results in the `done` cycle and again one cycle later to confirm they hold.

// File: rtl/rdx_pkg.sv
package rdx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_SUM  = 3'd1,
      ST_POS  = 3'd2,
      ST_NEG  = 3'd3,
      ST_DONE = 3'd4
   } rdx_state_t;

endpackage

// File: rtl/rdx_adv_unit.sv
module rdx_adv_unit #(
   parameter int NCOMP = 7,
   parameter int QW    = 16,
   localparam int AW   = QW + 1
) (
   input  logic [NCOMP*QW-1:0]       qa_flat,
   input  logic [NCOMP*QW-1:0]       qb_flat,
   output logic [NCOMP-1:0][AW-1:0]  adv,
   output logic [NCOMP-1:0][AW-1:0]  mag,
   output logic [NCOMP-1:0]          is_pos,
   output logic [NCOMP-1:0]          is_neg
);

   for (genvar g = 0; g < NCOMP; g++) begin : g_comp
      logic [QW-1:0] a_q, b_q;
      logic [AW-1:0] diff;
      assign a_q  = qa_flat[g*QW +: QW];
      assign b_q  = qb_flat[g*QW +: QW];
      // guard bit: sign-extend both operands by one bit
      assign diff = {a_q[QW-1], a_q} - {b_q[QW-1], b_q};
      assign adv[g]    = diff;
      assign is_neg[g] = diff[AW-1];
      assign is_pos[g] = !diff[AW-1] && (diff != '0);
      assign mag[g]    = diff[AW-1] ? (~diff + 1'b1) : diff;
   end

endmodule

// File: rtl/rdx_pick.sv
module rdx_pick #(
   parameter int NCOMP = 7,
   parameter int MW    = 17,
   localparam int IW   = (NCOMP > 1) ? $clog2(NCOMP) : 1
) (
   input  logic [NCOMP-1:0]          elig,
   input  logic [NCOMP-1:0][MW-1:0]  mag,
   output logic                      found,
   output logic [IW-1:0]             idx,
   output logic [MW-1:0]             best
);

   // strict greater-than keeps the lowest index on equal magnitudes
   always_comb begin
      found = 1'b0;
      idx   = '0;
      best  = '0;
      for (int i = 0; i < NCOMP; i++) begin
         if (elig[i] && (!found || (mag[i] > best))) begin
            found = 1'b1;
            idx   = IW'(i);
            best  = mag[i];
         end
      end
   end

endmodule

// File: rtl/rdx_explain_engine.sv
module rdx_explain_engine
   import rdx_pkg::*;
#(
   parameter int NCOMP = 7,
   parameter int QW    = 16,
   localparam int AW   = QW + 1,
   localparam int IW   = $clog2(NCOMP),
   localparam int SW   = AW + $clog2(NCOMP) + 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [NCOMP*QW-1:0]   q_a,
   input  logic [NCOMP*QW-1:0]   q_b,
   output logic                  busy,
   output logic                  done,
   output logic                  prefer,
   output logic [NCOMP-1:0]      pos_mask,
   output logic [NCOMP-1:0]      neg_mask,
   output logic                  necessary
);

   if (NCOMP < 2) begin : g_bad_ncomp
      $error("rdx_explain_engine: NCOMP must be at least 2");
   end
   if (QW < 2) begin : g_bad_qw
      $error("rdx_explain_engine: QW must be at least 2");
   end

   rdx_state_t               state;
   logic [NCOMP*QW-1:0]      qa_r, qb_r;
   logic [IW-1:0]            idx_r;
   logic signed [SW-1:0]     tot_r;
   logic [SW-1:0]            dis_r, psum_r, nsum_r;
   logic [AW-1:0]            pmin_r;
   logic [NCOMP-1:0]         pos_mask_r, neg_mask_r;
   logic                     prefer_r, nec_r;

   logic [NCOMP-1:0][AW-1:0] adv, mag;
   logic [NCOMP-1:0]         is_pos, is_neg;

   rdx_adv_unit #(.NCOMP(NCOMP), .QW(QW)) u_adv (
      .qa_flat (qa_r),
      .qb_flat (qb_r),
      .adv     (adv),
      .mag     (mag),
      .is_pos  (is_pos),
      .is_neg  (is_neg)
   );

   logic          p_found, n_found;
   logic [IW-1:0] p_idx, n_idx;
   logic [AW-1:0] p_mag, n_mag;

   rdx_pick #(.NCOMP(NCOMP), .MW(AW)) u_pick_pos (
      .elig  (is_pos & ~pos_mask_r),
      .mag   (mag),
      .found (p_found),
      .idx   (p_idx),
      .best  (p_mag)
   );

   rdx_pick #(.NCOMP(NCOMP), .MW(AW)) u_pick_neg (
      .elig  (is_neg & ~neg_mask_r),
      .mag   (mag),
      .found (n_found),
      .idx   (n_idx),
      .best  (n_mag)
   );

   // sequential accumulation: one component per cycle
   logic [AW-1:0]        adv_sel, mag_sel;
   logic                 neg_sel;
   logic signed [SW-1:0] tot_nx;
   logic [SW-1:0]        psum_nx, nsum_nx, v_val;

   always_comb begin
      adv_sel = adv[idx_r];
      mag_sel = mag[idx_r];
      neg_sel = is_neg[idx_r];
      tot_nx  = tot_r + {{(SW-AW){adv_sel[AW-1]}}, adv_sel};
      psum_nx = psum_r + SW'(p_mag);
      nsum_nx = nsum_r + SW'(n_mag);
      v_val   = psum_r - SW'(pmin_r);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         qa_r       <= '0;
         qb_r       <= '0;
         idx_r      <= '0;
         tot_r      <= '0;
         dis_r      <= '0;
         psum_r     <= '0;
         nsum_r     <= '0;
         pmin_r     <= '0;
         pos_mask_r <= '0;
         neg_mask_r <= '0;
         prefer_r   <= 1'b0;
         nec_r      <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  qa_r       <= q_a;
                  qb_r       <= q_b;
                  idx_r      <= '0;
                  tot_r      <= '0;
                  dis_r      <= '0;
                  psum_r     <= '0;
                  nsum_r     <= '0;
                  pmin_r     <= '0;
                  pos_mask_r <= '0;
                  neg_mask_r <= '0;
                  prefer_r   <= 1'b0;
                  nec_r      <= 1'b0;
                  state      <= ST_SUM;
               end
            end
            ST_SUM: begin
               tot_r <= tot_nx;
               if (neg_sel) dis_r <= dis_r + SW'(mag_sel);
               if (idx_r == IW'(NCOMP-1)) begin
                  prefer_r <= (tot_nx > 0);
                  state    <= ST_POS;
               end else begin
                  idx_r <= idx_r + 1'b1;
               end
            end
            ST_POS: begin
               if (p_found) begin
                  pos_mask_r[p_idx] <= 1'b1;
                  psum_r            <= psum_nx;
                  pmin_r            <= p_mag;
                  if (psum_nx > dis_r) state <= ST_NEG;
               end else if (pos_mask_r == '0) begin
                  state <= ST_DONE;
               end else begin
                  state <= ST_NEG;
               end
            end
            ST_NEG: begin
               if (n_found) begin
                  neg_mask_r[n_idx] <= 1'b1;
                  nsum_r            <= nsum_nx;
                  if (nsum_nx > v_val) begin
                     nec_r <= 1'b1;
                     state <= ST_DONE;
                  end
               end else begin
                  neg_mask_r <= '0;
                  state      <= ST_DONE;
               end
            end
            ST_DONE: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (state != ST_IDLE);
   assign done      = (state == ST_DONE);
   assign prefer    = prefer_r;
   assign pos_mask  = pos_mask_r;
   assign neg_mask  = neg_mask_r;
   assign necessary = nec_r;

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   restart_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SUM && idx_r == '0) |-> $past(state) == ST_IDLE);

   // R3
   disjoint_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (pos_mask & neg_mask) == '0);

   // R2
   prefer_has_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && prefer) |-> pos_mask != '0);

   // R6
   necessary_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (necessary == (neg_mask != '0)));

   // R4
   descending_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_POS && p_found && pos_mask_r != '0) |-> p_mag <= pmin_r);

   // R7
   empty_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && pos_mask == '0) |-> (!prefer && !necessary && neg_mask == '0));

endmodule

// File: tb/rdx_explain_engine_tb.sv
module rdx_explain_engine_tb;

   localparam int NC = 7;
   localparam int QW = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [NC*QW-1:0]  q_a = '0;
   logic [NC*QW-1:0]  q_b = '0;
   logic              busy, done, prefer, necessary;
   logic [NC-1:0]     pos_mask, neg_mask;

   int total = 0;
   int bad   = 0;
   int qa_v[NC];
   int qb_v[NC];
   int last_lat;
   bit finished = 0;

   always #5 clk = ~clk;

   rdx_explain_engine #(.NCOMP(NC), .QW(QW)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .q_a(q_a), .q_b(q_b),
      .busy(busy), .done(done), .prefer(prefer), .pos_mask(pos_mask),
      .neg_mask(neg_mask), .necessary(necessary)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic drive_vals();
      for (int i = 0; i < NC; i++) begin
         q_a[i*QW +: QW] = QW'(qa_v[i]);
         q_b[i*QW +: QW] = QW'(qb_v[i]);
      end
   endtask

   task automatic run_once(input string req);
      int cyc = 0;
      @(negedge clk);
      drive_vals();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done && cyc < 100) begin
         @(negedge clk);
         cyc++;
      end
      last_lat = cyc;
      chk(done, req, "done within bound", int'(done), 1);
   endtask

   task automatic expect_res(input string req, input int pref, input int pm,
                             input int nm, input int nec);
      chk(prefer == pref[0], req, "prefer", int'(prefer), pref);
      chk(pos_mask == NC'(pm), req, "pos_mask", int'(pos_mask), pm);
      chk(neg_mask == NC'(nm), req, "neg_mask", int'(neg_mask), nm);
      chk(necessary == nec[0], req, "necessary", int'(necessary), nec);
   endtask

   task automatic set_adv(input int a0, input int a1, input int a2, input int a3,
                          input int a4, input int a5, input int a6);
      qa_v = '{a0, a1, a2, a3, a4, a5, a6};
      qb_v = '{0, 0, 0, 0, 0, 0, 0};
   endtask

   task automatic t_reset();
      chk(!done && !busy, "R9", "reset done/busy", int'({done, busy}), 0);
      chk(pos_mask == '0 && neg_mask == '0 && !prefer && !necessary, "R9",
          "reset results", int'({pos_mask, neg_mask}), 0);
   endtask

   task automatic t_basic();
      // adv 10,-3,4,-2,0,6,-1 : d=6, pick c0 ; v=0 ; pick c1
      set_adv(10, -3, 4, -2, 0, 6, -1);
      qb_v = '{5, 0, 0, 0, 0, 0, 0};
      qa_v[0] = 15;
      run_once("R3");
      expect_res("R3 R5 R6", 1, 7'b0000001, 7'b0000010, 1);
      @(negedge clk);
      chk(!done, "R9", "done one cycle", int'(done), 0);
      chk(pos_mask == 7'b0000001 && neg_mask == 7'b0000010, "R9", "held after done",
          int'(pos_mask), 1);
   endtask

   task automatic t_exhaust();
      // adv 5,5,-4,-4,-4,1,0 : d=12, pos all {0,1,5}, v=10, neg {2,3,4}
      set_adv(5, 5, -4, -4, -4, 1, 0);
      run_once("R3");
      expect_res("R3 R5 R2", 0, 7'b0100011, 7'b0011100, 1);
   endtask

   task automatic t_ties();
      // adv 3,-1,7,7,0,0,0 : c2 wins the tie with c3
      set_adv(3, -1, 7, 7, 0, 0, 0);
      run_once("R4");
      expect_res("R4", 1, 7'b0000100, 7'b0000010, 1);
      // negative tie: 6,-2,-2,0.. d=4, pos {0}, v=0, neg c1 before c2
      set_adv(6, -2, -2, 0, 0, 0, 0);
      run_once("R4");
      expect_res("R4 neg tie", 1, 7'b0000001, 7'b0000010, 1);
   endtask

   task automatic t_no_nec();
      // adv 5,5,-5 : pos {0,1}, v=5, neg 5 not > 5
      set_adv(5, 5, -5, 0, 0, 0, 0);
      run_once("R5");
      expect_res("R5 R6", 1, 7'b0000011, 7'b0000000, 0);
   endtask

   task automatic t_no_pos();
      set_adv(0, -3, 0, -1, 0, 0, 0);
      run_once("R7");
      expect_res("R7", 0, 0, 0, 0);
   endtask

   task automatic t_equal();
      // equal sums: prefer 0 ; d=2, pos {0} exhausted, v=0, neg {1}
      set_adv(2, -2, 0, 0, 0, 0, 0);
      run_once("R2");
      expect_res("R2", 0, 7'b0000001, 7'b0000010, 1);
   endtask

   task automatic t_wide();
      qa_v = '{32767, -32768, 1, 0, 0, 0, 0};
      qb_v = '{-32768, 32767, 0, 0, 0, 0, 0};
      run_once("R1");
      // adv +65535,-65535,+1 : sum 1 ; pos {0,2} v=65535 ; neg 65535 not > v
      expect_res("R1", 1, 7'b0000101, 7'b0000000, 0);
   endtask

   task automatic t_latency();
      set_adv(0, 0, 0, 2, 0, 0, 0);
      run_once("R10");
      chk(last_lat == NC + 2, "R10", "latency", last_lat, NC + 2);
      expect_res("R10", 1, 7'b0001000, 0, 0);
   endtask

   task automatic t_busy();
      int cyc = 0;
      int dones = 0;
      set_adv(0, 0, 0, 2, 0, 0, 0);
      @(negedge clk);
      drive_vals();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk(busy, "R8", "busy during run", int'(busy), 1);
      // new inputs and a second start while busy
      set_adv(0, -3, 0, 0, 0, 0, 0);
      drive_vals();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done && cyc < 100) begin
         @(negedge clk);
         cyc++;
      end
      chk(done, "R8", "done reached", int'(done), 1);
      expect_res("R8", 1, 7'b0001000, 0, 0);
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         if (done) dones++;
      end
      chk(dones == 0, "R8", "no second run", dones, 0);
      chk(pos_mask == 7'b0001000, "R9", "held until next start", int'(pos_mask), 8);
   endtask

   initial begin
      #2000000;
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_basic();
      t_exhaust();
      t_ties();
      t_no_nec();
      t_no_pos();
      t_equal();
      t_wide();
      t_latency();
      t_busy();
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule